// File: doc/BRIEF.md
# Prescaled Countdown Timer with Vector Request

This block is a 32-bit down-counter clocked by a base tick through a power-of-two prescaler. Software programs a divide code, a start value and a control entry that holds an 8-bit request vector, a mask bit and a mode bit that selects single-run or repeating operation. When the count runs out, the block emits a one-cycle request pulse together with the vector from the control entry, unless the entry is masked.

Registers are reached through a plain write strobe with a 2-bit select and a combinational read port. Writing the start value restarts the count and the prescaler phase in the same cycle. The running count can be read at any time. Interrupt prioritisation and message delivery are left to the logic that consumes the pulse.

Top module: `tick_timer`

## Requirements
- R1: After reset the control entry reads 0x00010000 (masked, vector 0, single-run), the start value, divide code and running count all read 0, and no request pulse is raised.
- R2: The divide register keeps only bits 3, 1 and 0 of a written value (write data ANDed with 0xB); the other bits read back as 0.
- R3: With divide code v = {bit3, bit1, bit0}, one scaled tick occurs every 2^((v+1) mod 8) base ticks, counted from the last start-value write, so code 7 divides by 1 and code 0 divides by 2.
- R4: Writing the start value (select 1) loads it into the running count at that write and restarts the prescaler phase.
- R5: In single-run mode (control bit 17 clear), after e scaled ticks the count reads max(start − e, 0); exactly one expiry occurs, at e = start + 1, and the count then stays 0. A start value of 0 never expires.
- R6: In repeating mode (control bit 17 set), the count reads start − (e mod (start+1)) and an expiry occurs at every e that is a nonzero multiple of start+1. A start value of 0 never expires.
- R7: While control bit 16 (mask) is set, no request pulse is raised on expiry. Counting carries on, so clearing the mask resumes the same phase with no lost period.
- R8: An unmasked expiry raises the request pulse for exactly one clock cycle, with the request vector equal to control bits [7:0] at that moment.
- R9: Select codes are 0 control entry, 1 start value, 2 divide code, 3 running count. The running count is read-only, and a write to select 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_tick | input | 1 | One-cycle strobe of the undivided time base |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 32 | Read data (combinational) |
| req_pulse | output | 1 | One-cycle expiry request |
| req_vector | output | 8 | Vector carried with the request |

## Verification
The bench aims at the expiry boundary. A counter that fires when it reaches zero, rather than one scaled tick later, would pulse one tick early in both modes, and a repeating period of start instead of start+1 would drift against the modulo model within a few periods. A start value of 0 is driven in both modes; a design that treats 0 as a full wrap would pulse there. The mask is toggled mid-run, which catches a design that stops counting or resets its phase while masked. Divide codes with bit 2 set, and code 7 in particular, expose a wrong bit splice in the shift or an off-by-one in the divisor.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned CNT_W   = 32;
  localparam int unsigned VEC_W   = 8;
  localparam int unsigned SHIFT_W = 3;
  localparam int unsigned CTL_MASK_BIT = 16;
  localparam int unsigned CTL_REP_BIT  = 17;

  typedef enum logic [1:0] {
    SEL_CTL   = 2'd0,
    SEL_START = 2'd1,
    SEL_DIV   = 2'd2,
    SEL_COUNT = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             repeat_en;
    logic             mask;
    logic [VEC_W-1:0] vector;
  } ctl_t;

  function automatic logic [SHIFT_W-1:0] div_shift(input logic [3:0] code);
    logic [SHIFT_W-1:0] v;
    v = {code[3], code[1], code[0]};
    return v + 3'd1;
  endfunction
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned SHIFT_W = 3,
  localparam int unsigned PC_W = (1 << SHIFT_W) - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               base_tick,
  input  logic               restart,
  input  logic [SHIFT_W-1:0] shift,
  output logic               strobe
);
  logic [PC_W-1:0] cnt_q, cnt_d, limit;

  always_comb begin
    limit  = PC_W'((1 << shift) - 1);
    strobe = base_tick && !restart && (cnt_q >= limit);
    cnt_d  = cnt_q;
    if (restart)     cnt_d = '0;
    else if (strobe) cnt_d = '0;
    else if (base_tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: a scaled tick always starts a fresh prescale window
  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (cnt_q == '0));
endmodule

// File: rtl/tick_down_core.sv
module tick_down_core #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] start_val,
  input  logic             strobe,
  input  logic             repeat_en,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    expire  = 1'b0;
    if (load) begin
      cnt_d   = load_val;
      armed_d = (load_val != '0);
    end else if (strobe) begin
      if (cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end else if (repeat_en && (start_val != '0)) begin
        cnt_d  = start_val;
        expire = 1'b1;
      end else if (armed_q) begin
        expire  = 1'b1;
        armed_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign count = cnt_q;

  // R4: a start write lands in the running count
  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(load_val)));
  // R5: single-run count holds at zero
  a_r5_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!repeat_en && count == '0 && !load) |=> (count == '0));
  // R6: repeating mode reloads the start value at wrap
  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (repeat_en && strobe && !load && count == '0 && start_val != '0)
      |=> (count == $past(start_val)));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_tick,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [31:0]      wr_data,
  input  logic [1:0]       rd_sel,
  output logic [31:0]      rd_data,
  output logic             req_pulse,
  output logic [VEC_W-1:0] req_vector
);
  ctl_t             ctl_q, ctl_d;
  logic [CNT_W-1:0] start_q, start_d;
  logic [3:0]       div_q, div_d;
  logic             pulse_q, pulse_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             wr_ctl, wr_start, wr_div;
  logic             strobe, expire;
  logic [CNT_W-1:0] count;

  assign wr_ctl   = wr_en && (reg_sel_e'(wr_sel) == SEL_CTL);
  assign wr_start = wr_en && (reg_sel_e'(wr_sel) == SEL_START);
  assign wr_div   = wr_en && (reg_sel_e'(wr_sel) == SEL_DIV);

  tick_prescaler #(.SHIFT_W(SHIFT_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .restart(wr_start),
    .shift(div_shift(div_q)), .strobe(strobe)
  );

  tick_down_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .load(wr_start), .load_val(wr_data),
    .start_val(start_q), .strobe(strobe), .repeat_en(ctl_q.repeat_en),
    .count(count), .expire(expire)
  );

  always_comb begin
    ctl_d   = ctl_q;
    start_d = start_q;
    div_d   = div_q;
    if (wr_ctl) begin
      ctl_d.repeat_en = wr_data[CTL_REP_BIT];
      ctl_d.mask      = wr_data[CTL_MASK_BIT];
      ctl_d.vector    = wr_data[VEC_W-1:0];
    end
    if (wr_start) start_d = wr_data;
    if (wr_div)   div_d   = wr_data[3:0] & 4'hB;
    pulse_d = expire && !ctl_q.mask;
    vec_d   = expire ? ctl_q.vector : vec_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '{repeat_en: 1'b0, mask: 1'b1, vector: '0};
      start_q <= '0;
      div_q   <= '0;
      pulse_q <= 1'b0;
      vec_q   <= '0;
    end else begin
      ctl_q   <= ctl_d;
      start_q <= start_d;
      div_q   <= div_d;
      pulse_q <= pulse_d;
      vec_q   <= vec_d;
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (reg_sel_e'(rd_sel))
      SEL_CTL: begin
        rd_data[CTL_REP_BIT]  = ctl_q.repeat_en;
        rd_data[CTL_MASK_BIT] = ctl_q.mask;
        rd_data[VEC_W-1:0]    = ctl_q.vector;
      end
      SEL_START: rd_data = start_q;
      SEL_DIV:   rd_data = {28'd0, div_q};
      SEL_COUNT: rd_data = count;
    endcase
  end

  assign req_pulse  = pulse_q;
  assign req_vector = vec_q;

  // R7: a masked entry never yields a request
  a_r7_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.mask |=> !req_pulse);
  // R8: request lasts a single cycle
  a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    req_pulse |=> !req_pulse);
  // R2: only bits 3, 1, 0 survive in the divide code
  a_r2_div_bits: assert property (@(posedge clk) disable iff (!rst_n)
    div_q[2] == 1'b0);
endmodule

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic [1:0]  rd_sel = 2'd3;
  logic [31:0] rd_data;
  logic        req_pulse;
  logic [7:0]  req_vector;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // model state
  longint m_n;
  longint m_start;
  int     m_shift;
  bit     m_rep, m_mask;
  logic [7:0] m_vec;

  always #4 clk = ~clk;

  tick_timer u_tick_timer (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .req_pulse(req_pulse), .req_vector(req_vector)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int shift_of(input logic [3:0] code);
    int v;
    v = {29'd0, code[3], code[1], code[0]};
    return (v + 1) % 8;
  endfunction

  function automatic longint exp_count(input longint n);
    longint e;
    e = n >> m_shift;
    if (m_rep) return m_start - (e % (m_start + 1));
    return (e >= m_start) ? 0 : m_start - e;
  endfunction

  function automatic bit exp_expiry(input longint n);
    longint e;
    if (m_start == 0) return 0;
    if ((n % (longint'(1) << m_shift)) != 0) return 0;
    e = n >> m_shift;
    if (m_rep) return (e > 0) && ((e % (m_start + 1)) == 0);
    return e == m_start + 1;
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    rd_sel = sel;
    #1 d = rd_data;
    rd_sel = 2'd3;
  endtask

  task automatic set_ctl(input bit rep, input bit msk, input logic [7:0] v);
    m_rep = rep; m_mask = msk; m_vec = v;
    wr(2'd0, {14'd0, rep, msk, 8'd0, v});
  endtask

  task automatic set_div(input logic [3:0] code);
    m_shift = shift_of(code);
    wr(2'd2, {28'd0, code});
  endtask

  task automatic load(input longint s);
    m_start = s; m_n = 0;
    wr(2'd1, s[31:0]);
  endtask

  // one base tick, then checks on count and request
  task automatic tick_check(input string req);
    bit pe;
    @(negedge clk);
    base_tick = 1'b1;
    @(negedge clk);
    base_tick = 1'b0;
    m_n++;
    pe = exp_expiry(m_n) && !m_mask;
    chk(rd_data == exp_count(m_n)[31:0], req, rd_data, exp_count(m_n));
    chk(req_pulse == pe, {req, " pulse"}, req_pulse, pe);
    if (pe) chk(req_vector == m_vec, "R8 vector", req_vector, m_vec);
  endtask

  task automatic count_pulses(input int ticks, output int pulses);
    pulses = 0;
    for (int i = 0; i < ticks; i++) begin
      @(negedge clk); base_tick = 1'b1;
      @(negedge clk); base_tick = 1'b0;
      m_n++;
      if (req_pulse) pulses++;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    int p;
    void'($urandom(32'd20240611));
    m_n = 0; m_start = 0; m_shift = 1; m_rep = 0; m_mask = 1; m_vec = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, d); chk(d == 32'h0001_0000, "R1 ctl", d, 32'h0001_0000);
    rd(2'd1, d); chk(d == 0, "R1 start", d, 0);
    rd(2'd2, d); chk(d == 0, "R1 div", d, 0);
    rd(2'd3, d); chk(d == 0, "R1 count", d, 0);
    chk(req_pulse == 1'b0, "R1 pulse", req_pulse, 0);

    // R2 divide masking
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, d); chk(d == 32'hB, "R2 div mask", d, 32'hB);

    // R9 count is read-only
    set_div(4'hB);
    load(5);
    wr(2'd3, 32'h1234);
    rd(2'd3, d); chk(d == 5, "R9 ro count", d, 5);

    // R3 code 0 divides by 2, code 7 (0xB) by 1
    set_ctl(1'b0, 1'b0, 8'h41);
    set_div(4'h0);
    load(3);
    for (int i = 0; i < 10; i++) tick_check("R3 div2 R5");
    set_div(4'hB);
    load(3);
    for (int i = 0; i < 8; i++) tick_check("R3 div1 R5");

    // R5 single-run fires once then holds
    load(2);
    count_pulses(20, p);
    chk(p == 1, "R5 one expiry", p, 1);
    rd(2'd3, d); chk(d == 0, "R5 hold zero", d, 0);
    load(0);
    count_pulses(10, p);
    chk(p == 0, "R5 zero start", p, 0);

    // R6 repeating, start 0 never fires
    set_ctl(1'b1, 1'b0, 8'h22);
    load(0);
    count_pulses(12, p);
    chk(p == 0, "R6 zero start", p, 0);
    load(2);
    for (int i = 0; i < 14; i++) tick_check("R6 periodic");

    // R4 restart mid-run
    load(9);
    for (int i = 0; i < 3; i++) tick_check("R4 run");
    load(7);
    rd(2'd3, d); chk(d == 7, "R4 restart", d, 7);
    for (int i = 0; i < 4; i++) tick_check("R4 after restart");
    load(64'hFFFF_FFFF);
    tick_check("R4 full width");

    // R7 mask toggled mid-run keeps phase
    set_ctl(1'b1, 1'b1, 8'h7E);
    load(3);
    for (int i = 0; i < 9; i++) tick_check("R7 masked");
    set_ctl(1'b1, 1'b0, 8'h7E);
    for (int i = 0; i < 9; i++) tick_check("R7 unmasked");

    // random runs
    for (int r = 0; r < 40; r++) begin
      logic [3:0] code;
      int nt;
      code = 4'($urandom_range(0, 15)) & 4'hB;
      if (code == 4'h3 || code == 4'h8) code = 4'hB;
      set_div(code);
      set_ctl(1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0),
              8'($urandom_range(0, 255)));
      load(longint'($urandom_range(0, 12)));
      nt = $urandom_range(10, 120);
      for (int t = 0; t < nt; t++) begin
        if ($urandom_range(0, 19) == 0)
          set_ctl(m_rep, ~m_mask, 8'($urandom_range(0, 255)));
        tick_check(m_rep ? "R6 rand R7" : "R5 rand R7");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule